// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 12-bit successive-approximation converter. It waits for a start event from one of four selectable sources, then runs a binary search. It drives a trial code to an external DAC and reads back a one-bit comparator verdict for each bit, starting at the MSB. The pace of the decisions comes from the system clock divided by a programmable prescaler. A busy flag is high for the whole conversion.

When the last bit has been decided, the controller writes a formatted 16-bit result word and raises a sticky completion flag. If interrupts are enabled, it also raises an interrupt request. The result word can be right- or left-justified. It can hold an unsigned single-ended code or a sign-extended two's-complement differential code. Software reads the word, then clears the flag. The DAC, comparator, gain stage and input multiplexer are outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: `start_sel` picks the only trigger that is honoured: 2'b00 is `sw_start`, 2'b01 is `tmr_a_ovf`, 2'b10 is `tmr_b_ovf`, and 2'b11 is a rising edge of `ext_start`. Pulses on the other three sources start nothing.
- R2: `ext_start` is synchronised through two flops and edge-detected. After the pin rises, `busy` is still low following the second clock edge and is high following the third.
- R3: With prescale value N, `busy` stays high for exactly 13*(N+1) clock cycles: one sample period plus one period for each of the 12 bit decisions.
- R4: A trigger that arrives while `busy` is high is ignored. It neither lengthens the running conversion nor starts a new one after it.
- R5: Decisions run MSB first. While bit k is on trial, `dac_code` holds the bits already kept, bit k set, and lower bits clear. `cmp_in`=1 keeps the bit. Against an input of value V, the final code is min(V, 4095). `dac_code` is 0 whenever `busy` is low.
- R6: The cycle `busy` falls at the end of a conversion, `done_flag` rises. It stays set until a `flag_clr` pulse clears it, and a set in the same cycle wins over a clear. After reset `busy`, `done_flag`, `irq`, `result` and `dac_code` are all 0.
- R7: `irq` is high exactly when `done_flag` and `irq_en` are both high.
- R8: With `left_just`=0 in single-ended mode, `result[11:0]` holds the code and `result[15:12]` is zero. An input at or above full scale gives 0x0FFF, and half scale gives 0x0800.
- R9: With `left_just`=1, `result[15:4]` holds the 12-bit value and `result[3:0]` is zero.
- R10: With `diff_mode`=1, the raw code's MSB is inverted to form a 12-bit two's-complement value, which is sign-extended when right-justified. Zero input gives 0xF800, full scale gives 0x07FF, raw 0x123 gives 0xF923, and raw 0x800 gives 0x0000.
- R11: While `enable` is 0, every trigger is ignored. Dropping `enable` during a conversion ends it at the next edge without setting `done_flag` or changing `result`.
- R12: `result` changes only at the end of a completed conversion. While a conversion runs, it keeps the previous completed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable |
| start_sel | input | 2 | Start source select |
| prescale | input | 5 | Decision clock divider N (divide by N+1) |
| left_just | input | 1 | 1 = left-justified result |
| diff_mode | input | 1 | 1 = differential (two's-complement) coding |
| irq_en | input | 1 | Interrupt enable |
| sw_start | input | 1 | Software start pulse |
| tmr_a_ovf | input | 1 | First timer overflow pulse |
| tmr_b_ovf | input | 1 | Second timer overflow pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| flag_clr | input | 1 | Clear pulse for the completion flag |
| cmp_in | input | 1 | Comparator verdict, 1 = input at or above trial |
| dac_code | output | 12 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt request |
| result | output | 16 | Formatted result word |

## Verification
The hardest behaviour to reach from the ports is a trigger that lands in the middle of a conversion. It must leave the bit-search timing intact and leave nothing pending, while the result word must still show the previous conversion. The bench models the analog input as a value compared against `dac_code` every cycle. It completes one conversion, then starts a second one against a different input value. Partway through the second conversion it fires the selected trigger again. It then checks three things: `busy` lasts exactly 13*(N+1) cycles, `result` holds the earlier value until the end, and no conversion follows. Aborting a conversion by dropping `enable` is reached the same way.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic [1:0] {
    SRC_SW    = 2'b00,
    SRC_TMR_A = 2'b01,
    SRC_TMR_B = 2'b10,
    SRC_EXT   = 2'b11
  } start_src_e;
endpackage

// File: rtl/sar_conv_trigger.sv
module sar_conv_trigger
  import sar_conv_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       busy,
  input  logic [1:0] start_sel,
  input  logic       sw_start,
  input  logic       tmr_a_ovf,
  input  logic       tmr_b_ovf,
  input  logic       ext_start,
  output logic       start
);
  logic [SYNC_N:0] ext_q;
  logic            ext_rise;
  logic            sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[SYNC_N-1:0], ext_start};
  end

  assign ext_rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];

  always_comb begin
    unique case (start_src_e'(start_sel))
      SRC_SW:    sel_hit = sw_start;
      SRC_TMR_A: sel_hit = tmr_a_ovf;
      SRC_TMR_B: sel_hit = tmr_b_ovf;
      default:   sel_hit = ext_rise;
    endcase
  end

  assign start = enable & ~busy & sel_hit;
endmodule

// File: rtl/sar_conv_prescaler.sv
module sar_conv_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div_n,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  assign tick = run & (cnt_q == div_n);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              tick,
  input  logic              cmp_in,
  output logic              busy,
  output logic [DATA_W-1:0] dac_code,
  output logic              finish,
  output logic [DATA_W-1:0] final_code
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic              busy_q, busy_d;
  logic              sampling_q, sampling_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] trial_bit;

  assign trial_bit = DATA_W'(1) << idx_q;
  assign dac_code  = (busy_q && !sampling_q) ? (acc_q | trial_bit) : '0;

  always_comb begin
    busy_d     = busy_q;
    sampling_d = sampling_q;
    idx_d      = idx_q;
    acc_d      = acc_q;
    finish     = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d     = 1'b1;
        sampling_d = 1'b1;
        idx_d      = TOP_IDX;
        acc_d      = '0;
      end
    end else if (!enable) begin
      busy_d = 1'b0;
    end else if (tick) begin
      if (sampling_q) begin
        sampling_d = 1'b0;
      end else begin
        acc_d[idx_q] = cmp_in;
        if (idx_q == '0) begin
          busy_d = 1'b0;
          finish = 1'b1;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
    end
  end

  assign final_code = acc_d;
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      sampling_q <= 1'b0;
      idx_q      <= '0;
      acc_q      <= '0;
    end else begin
      busy_q     <= busy_d;
      sampling_q <= sampling_d;
      idx_q      <= idx_d;
      acc_q      <= acc_d;
    end
  end
endmodule

// File: rtl/sar_conv_format.sv
module sar_conv_format #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic [DATA_W-1:0] code,
  input  logic              diff_mode,
  input  logic              left_just,
  output logic [OUT_W-1:0]  word
);
  localparam int PAD_W = OUT_W - DATA_W;

  logic [DATA_W-1:0] coded;

  always_comb begin
    coded = code;
    if (diff_mode) coded[DATA_W-1] = ~code[DATA_W-1];
  end

  always_comb begin
    if (left_just)      word = {coded, {PAD_W{1'b0}}};
    else if (diff_mode) word = {{PAD_W{coded[DATA_W-1]}}, coded};
    else                word = {{PAD_W{1'b0}}, coded};
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        start_sel,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              left_just,
  input  logic              diff_mode,
  input  logic              irq_en,
  input  logic              sw_start,
  input  logic              tmr_a_ovf,
  input  logic              tmr_b_ovf,
  input  logic              ext_start,
  input  logic              flag_clr,
  input  logic              cmp_in,
  output logic [DATA_W-1:0] dac_code,
  output logic              busy,
  output logic              done_flag,
  output logic              irq,
  output logic [OUT_W-1:0]  result
);
  logic [1:0]        rst_sync_q;
  logic              rst_l;
  logic              start, tick, finish;
  logic [DATA_W-1:0] final_code;
  logic [OUT_W-1:0]  word;
  logic              flag_q, flag_d;
  logic [OUT_W-1:0]  result_q, result_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  sar_conv_trigger #(.SYNC_N(2)) u_trig (
    .clk(clk), .rst_n(rst_l), .enable(enable), .busy(busy),
    .start_sel(start_sel), .sw_start(sw_start), .tmr_a_ovf(tmr_a_ovf),
    .tmr_b_ovf(tmr_b_ovf), .ext_start(ext_start), .start(start)
  );

  sar_conv_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_l), .run(busy), .div_n(prescale), .tick(tick)
  );

  sar_conv_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_l), .enable(enable), .start(start), .tick(tick),
    .cmp_in(cmp_in), .busy(busy), .dac_code(dac_code), .finish(finish),
    .final_code(final_code)
  );

  sar_conv_format #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_fmt (
    .code(final_code), .diff_mode(diff_mode), .left_just(left_just),
    .word(word)
  );

  always_comb begin
    flag_d   = flag_q;
    result_d = result_q;
    if (flag_clr) flag_d = 1'b0;
    if (finish) begin
      flag_d   = 1'b1;
      result_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      flag_q   <= 1'b0;
      result_q <= '0;
    end else begin
      flag_q   <= flag_d;
      result_q <= result_d;
    end
  end

  assign done_flag = flag_q;
  assign result    = result_q;
  assign irq       = flag_q & irq_en;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              irq_en,
  input logic              busy,
  input logic              done_flag,
  input logic              irq,
  input logic [DATA_W-1:0] dac_code,
  input logic [OUT_W-1:0]  result
);
  // R6
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(enable)) |-> done_flag);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en |-> !irq) and ((done_flag && irq_en) |-> irq));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  // R5
  idle_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  // R11
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_l), .enable(enable), .irq_en(irq_en), .busy(busy),
  .done_flag(done_flag), .irq(irq), .dac_code(dac_code), .result(result)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, left_just, diff_mode, irq_en;
  logic [1:0]  start_sel;
  logic [4:0]  prescale;
  logic        sw_start, tmr_a_ovf, tmr_b_ovf, ext_start, flag_clr;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        busy, done_flag, irq;
  logic [15:0] result;
  logic [12:0] vin;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign cmp_in = (vin >= {1'b0, dac_code});

  sar_conv_ctrl u_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_sel(start_sel),
    .prescale(prescale), .left_just(left_just), .diff_mode(diff_mode),
    .irq_en(irq_en), .sw_start(sw_start), .tmr_a_ovf(tmr_a_ovf),
    .tmr_b_ovf(tmr_b_ovf), .ext_start(ext_start), .flag_clr(flag_clr),
    .cmp_in(cmp_in), .dac_code(dac_code), .busy(busy),
    .done_flag(done_flag), .irq(irq), .result(result)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [12:0] v, input logic d, input logic lj);
    logic [11:0] raw;
    logic [11:0] s;
    raw = (v > 13'd4095) ? 12'hFFF : v[11:0];
    s   = d ? (raw ^ 12'h800) : raw;
    if (lj)     return {s, 4'h0};
    else if (d) return {{4{s[11]}}, s};
    else        return {4'h0, s};
  endfunction

  task automatic pulse_sw();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6 reset busy", busy, 0);
    chk("R6 reset flag", done_flag, 0);
    chk("R6 reset irq", irq, 0);
    chk("R6 reset result", result, 0);
    chk("R6 reset dac", dac_code, 0);
  endtask

  task automatic t_basic(input logic [12:0] v, input logic [4:0] n,
                         input logic d, input logic lj, input string tag);
    int len;
    vin = v; prescale = n; diff_mode = d; left_just = lj;
    @(negedge clk) sw_start = 1'b1;
    len = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sw_start = 1'b0;
      if (!busy) break;
      len++;
    end
    chk({"R3 busy length ", tag}, len, 13 * (n + 1));
    chk({"R6 flag set ", tag}, done_flag, 1);
    chk({tag, " result"}, result, expect_word(v, d, lj));
    clear_flag();
  endtask

  task automatic t_flag_irq();
    irq_en = 1'b1;
    vin = 13'd100; prescale = 5'd0; diff_mode = 1'b0; left_just = 1'b0;
    pulse_sw();
    wait_idle();
    chk("R7 irq with enable", irq, 1);
    @(negedge clk) irq_en = 1'b0;
    @(negedge clk);
    chk("R7 irq masked", irq, 0);
    chk("R6 flag sticky", done_flag, 1);
    irq_en = 1'b1;
    clear_flag();
    chk("R6 flag cleared", done_flag, 0);
    chk("R7 irq after clear", irq, 0);
  endtask

  task automatic t_sources();
    prescale = 5'd0; vin = 13'd7;
    start_sel = 2'b01;
    pulse_sw();
    @(negedge clk) tmr_b_ovf = 1'b1;
    @(negedge clk) tmr_b_ovf = 1'b0;
    chk("R1 wrong sources ignored", busy, 0);
    @(negedge clk) tmr_a_ovf = 1'b1;
    @(negedge clk) tmr_a_ovf = 1'b0;
    chk("R1 timer A starts", busy, 1);
    wait_idle(); clear_flag();
    start_sel = 2'b10;
    @(negedge clk) tmr_a_ovf = 1'b1;
    @(negedge clk) tmr_a_ovf = 1'b0;
    chk("R1 timer A ignored on sel 10", busy, 0);
    @(negedge clk) tmr_b_ovf = 1'b1;
    @(negedge clk) tmr_b_ovf = 1'b0;
    chk("R1 timer B starts", busy, 1);
    wait_idle(); clear_flag();
    start_sel = 2'b00;
  endtask

  task automatic t_ext();
    prescale = 5'd0; vin = 13'd9;
    start_sel = 2'b11;
    pulse_sw();
    chk("R1 sw ignored on ext sel", busy, 0);
    @(negedge clk) ext_start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 not busy after 2 edges", busy, 0);
    @(negedge clk);
    chk("R2 busy after 3 edges", busy, 1);
    wait_idle();
    chk("R2 ext result", result, 16'h0009);
    @(negedge clk) ext_start = 1'b0;
    clear_flag();
    start_sel = 2'b00;
  endtask

  task automatic t_busy_ignore();
    int len;
    logic [15:0] prev;
    prescale = 5'd1; diff_mode = 1'b0; left_just = 1'b0;
    vin = 13'h2AB; pulse_sw(); wait_idle(); clear_flag();
    prev = result;
    vin = 13'h5C1;
    @(negedge clk) sw_start = 1'b1;
    len = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sw_start = (len == 9);
      if (!busy) break;
      if (len == 5) chk("R12 result held while busy", result, prev);
      len++;
    end
    sw_start = 1'b0;
    chk("R4 length unchanged by retrigger", len, 26);
    repeat (3) @(negedge clk);
    chk("R4 no queued restart", busy, 0);
    chk("R5 second result", result, 16'h05C1);
    clear_flag();
  endtask

  task automatic t_enable();
    logic [15:0] prev;
    prescale = 5'd0; vin = 13'd33;
    prev = result;
    enable = 1'b0;
    pulse_sw();
    chk("R11 disabled trigger ignored", busy, 0);
    @(negedge clk) enable = 1'b1;
    pulse_sw();
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 abort clears busy", busy, 0);
    chk("R11 abort no flag", done_flag, 0);
    chk("R11 abort keeps result", result, prev);
    enable = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; start_sel = 2'b00; prescale = 5'd0;
    left_just = 1'b0; diff_mode = 1'b0; irq_en = 1'b0;
    sw_start = 1'b0; tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0;
    ext_start = 1'b0; flag_clr = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic(13'h5A3, 5'd2, 1'b0, 1'b0, "R5 R8 right");
    t_basic(13'd4096, 5'd0, 1'b0, 1'b0, "R8 saturate");
    t_basic(13'h800, 5'd3, 1'b0, 1'b0, "R8 half");
    t_basic(13'd4096, 5'd1, 1'b0, 1'b1, "R9 left full");
    t_basic(13'h5A3, 5'd0, 1'b0, 1'b1, "R9 left");
    t_basic(13'h123, 5'd0, 1'b1, 1'b0, "R10 neg");
    t_basic(13'd0, 5'd0, 1'b1, 1'b0, "R10 min");
    t_basic(13'd4096, 5'd0, 1'b1, 1'b0, "R10 max");
    t_basic(13'h800, 5'd0, 1'b1, 1'b1, "R10 zero left");
    t_flag_irq();
    t_sources();
    t_ext();
    t_busy_ignore();
    t_enable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule